// File: doc/BRIEF.md
# Windowed Multi-Queue Message Mailbox

The block lets processors exchange fixed-size messages over a plain 32-bit register bus. A bus address either falls in a data window or in a status region. Each data window is tied to one hardware queue. A message is sixteen 32-bit words. A producer fills a per-queue staging buffer word by word and commits the message by writing the last word of the window. A consumer reads the head message through the same window, and reading its last word removes it from the queue.

The status region holds one state word per queue. The state word carries the number of pending messages and a sticky overflow flag. Queues marked as receive queues by a parameter raise an interrupt while they hold at least one message. Several proxy windows may address the same queue, so more than one agent can reach a queue through its own address range. The default build has four queues, four messages per queue and two proxy windows. The address map and the field positions do not change when these parameters change.

Top module: `msgq_hub`

## Requirements
- R1: A data access goes to proxy p, queue q, register r at byte address p*0x10000 + q*0x80 + r*4 (address bit 19 clear). Registers 16..31 hold message words 0..15. Proxy indices below NUM_PROXY (default 2) all reach the same queue.
- R2: A write to register 31 commits one message into the queue: the words staged through registers 16..30, plus the word written to register 31 as word 15. The pending count rises by one.
- R3: A commit to a queue that already holds DEPTH (default 4) messages is dropped. It sets a sticky overflow flag in bit 0 of that queue's state word, and the count stays at DEPTH.
- R4: A read of register 31 returns word 15 of the head message and removes that message. Messages leave each queue in commit order.
- R5: A read of registers 16..30 returns the matching word of the head message and changes no state.
- R6: On an empty queue, every data read returns zero, and a read of register 31 leaves the count at zero.
- R7: The state word of queue q is read at 0x80000 + q*4. Bits 23:12 hold the pending count, bit 0 holds the overflow flag, and all other bits read zero.
- R8: For a queue whose bit in RX_MASK is set (default 4'b1010, so queues 1 and 3), irq_o[q] is high exactly while the count is nonzero. For all other queues irq_o[q] stays low.
- R9: Each commit clears the staging buffer, so any word not written for the next message reads back as zero.
- R10: These accesses read zero, and writing them changes no state: registers 0..15, a queue index of N_QUEUES or more, a proxy index of NUM_PROXY or more, and status offsets beyond the last queue.
- R11: After reset, all counts and overflow flags are zero, irq_o is all low and bus_rdata is zero.
- R12: bus_rdata takes the read value on the clock edge that samples bus_rd and holds it until the next read. When bus_wr and bus_rd are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (20) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | N_QUEUES | Per-queue receive interrupt |

## Verification
The bench tests message transfer with several stimulus patterns:
- Complete sixteen-word messages are written through one proxy window and read back through the other. This separates a correct queue mapping from a mapping that depends on the proxy.
- Several messages are committed back to back and then drained. This shows ordering and pointer wrap-around.
- Short messages are written by touching only a few words before the commit. This exposes any staging data that survives a commit.
- A fifth commit is sent to a full queue, and reads are made from a drained queue. These show the drop and overflow rules and the empty-read rules.
- Accesses go to unmapped registers, queues, proxies and status offsets, and the state words are then read back. This shows that the ignored accesses left no trace.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
   localparam int WORD_W      = 32;
   localparam int MSG_WORDS   = 16;
   localparam int PROXY_LSB   = 16;
   localparam int QUEUE_LSB   = 7;
   localparam int WORD_LSB    = 2;
   localparam int CNT_LSB     = 12;
   localparam int CNT_FIELD_W = 12;
   localparam int OVF_BIT     = 0;

   function automatic logic [WORD_W-1:0] state_word(input logic [CNT_FIELD_W-1:0] cnt,
                                                    input logic ovf);
      logic [WORD_W-1:0] w;
      w = '0;
      w[CNT_LSB +: CNT_FIELD_W] = cnt;
      w[OVF_BIT] = ovf;
      return w;
   endfunction
endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
   import msgq_pkg::*;
#(
   parameter int N_QUEUES  = 4,
   parameter int NUM_PROXY = 2,
   parameter int ADDR_W    = 20,
   parameter int QS_W      = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              dat_hit,
   output logic              sts_hit,
   output logic [QS_W-1:0]   qsel,
   output logic [3:0]        widx
);
   localparam int TOP = ADDR_W - 1;

   logic [31:0] sts_off;
   logic [31:0] proxy;
   logic [31:0] qfield;
   logic        aligned;

   always_comb begin
      sts_off = 32'(addr[TOP-1:0]);
      proxy   = 32'(addr[TOP-1:PROXY_LSB]);
      qfield  = 32'(addr[PROXY_LSB-1:QUEUE_LSB]);
      aligned = (addr[WORD_LSB-1:0] == '0);
      sts_hit = addr[TOP] && aligned && (sts_off < 32'(N_QUEUES) * 32'd4);
      // Bit QUEUE_LSB-1 set means register index 16..31 (message words)
      dat_hit = !addr[TOP] && aligned && (proxy < 32'(NUM_PROXY)) &&
                (qfield < 32'(N_QUEUES)) && addr[QUEUE_LSB-1];
      widx    = addr[QUEUE_LSB-2:WORD_LSB];
      qsel    = sts_hit ? QS_W'(sts_off >> WORD_LSB) : QS_W'(qfield);
   end
endmodule

// File: rtl/msgq_slot.sv
module msgq_slot
   import msgq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int WORDS = 16,
   parameter int CNT_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     commit,
   input  logic                     pop,
   input  logic [$clog2(WORDS)-1:0] widx,
   input  logic [WORD_W-1:0]        wdata,
   output logic [WORD_W-1:0]        head_word,
   output logic [CNT_W-1:0]         count,
   output logic                     ovf
);
   localparam int IDX_W = $clog2(WORDS);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   logic [WORD_W-1:0] stage [WORDS-1];
   logic [WORD_W-1:0] store [DEPTH][WORDS];
   logic [PTR_W-1:0]  wp, rp;
   logic              full, empty, do_push, do_pop;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      if (p == PTR_W'(DEPTH - 1)) return '0;
      return p + 1'b1;
   endfunction

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = commit && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS - 1; i++) stage[i] <= '0;
      end else if (commit) begin
         for (int i = 0; i < WORDS - 1; i++) stage[i] <= '0;
      end else if (wr_en && widx != LAST) begin
         stage[widx] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         for (int i = 0; i < WORDS - 1; i++) store[wp][i] <= stage[i];
         store[wp][WORDS-1] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (do_push) wp <= bump(wp);
         if (do_pop)  rp <= bump(rp);
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
         if (commit && full) ovf <= 1'b1;
      end
   end

   assign head_word = empty ? '0 : store[rp][widx];
endmodule

// File: rtl/msgq_hub.sv
module msgq_hub
   import msgq_pkg::*;
#(
   parameter int          N_QUEUES  = 4,
   parameter int          DEPTH     = 4,
   parameter int          NUM_PROXY = 2,
   parameter int          ADDR_W    = 20,
   parameter logic [63:0] RX_MASK   = 64'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_QUEUES-1:0] irq_o
);
   localparam int QS_W  = (N_QUEUES > 1) ? $clog2(N_QUEUES) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(MSG_WORDS);

   if (N_QUEUES < 1 || N_QUEUES > 64) begin : g_bad_queues
      $error("N_QUEUES must lie in 1..64");
   end
   if (DEPTH < 1 || DEPTH > 128) begin : g_bad_depth
      $error("DEPTH must lie in 1..128");
   end
   if (ADDR_W < PROXY_LSB + 2) begin : g_bad_addr
      $error("ADDR_W too small for the window map");
   end
   if (NUM_PROXY < 1 || NUM_PROXY > (1 << (ADDR_W - 1 - PROXY_LSB))) begin : g_bad_proxy
      $error("NUM_PROXY does not fit below the status region");
   end
   if (N_QUEUES * 4 > (1 << (ADDR_W - 1))) begin : g_bad_status
      $error("status region too small for N_QUEUES");
   end

   logic                           dat_hit, sts_hit;
   logic [QS_W-1:0]                qsel;
   logic [IDX_W-1:0]               widx;
   logic [N_QUEUES-1:0][CNT_W-1:0] q_cnt;
   logic [N_QUEUES-1:0]            q_ovf;
   logic [31:0]                    head [N_QUEUES];
   logic                           rd_act;
   logic [31:0]                    rd_next;

   msgq_decode #(
      .N_QUEUES (N_QUEUES),
      .NUM_PROXY(NUM_PROXY),
      .ADDR_W   (ADDR_W),
      .QS_W     (QS_W)
   ) u_dec (
      .addr   (bus_addr),
      .dat_hit(dat_hit),
      .sts_hit(sts_hit),
      .qsel   (qsel),
      .widx   (widx)
   );

   assign rd_act = bus_rd && !bus_wr;

   for (genvar q = 0; q < N_QUEUES; q++) begin : g_q
      logic sel, wr_q, commit_q, pop_q;
      assign sel      = dat_hit && (qsel == QS_W'(q));
      assign wr_q     = bus_wr && sel;
      assign commit_q = wr_q && (widx == IDX_W'(MSG_WORDS - 1));
      assign pop_q    = rd_act && sel && (widx == IDX_W'(MSG_WORDS - 1));

      msgq_slot #(
         .DEPTH(DEPTH),
         .WORDS(MSG_WORDS),
         .CNT_W(CNT_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_q),
         .commit   (commit_q),
         .pop      (pop_q),
         .widx     (widx),
         .wdata    (bus_wdata),
         .head_word(head[q]),
         .count    (q_cnt[q]),
         .ovf      (q_ovf[q])
      );

      if (RX_MASK[q]) begin : g_rx
         assign irq_o[q] = (q_cnt[q] != '0);
      end else begin : g_tx
         assign irq_o[q] = 1'b0;
      end
   end

   always_comb begin
      rd_next = '0;
      if (sts_hit)      rd_next = state_word(CNT_FIELD_W'(q_cnt[qsel]), q_ovf[qsel]);
      else if (dat_hit) rd_next = head[qsel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_act) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/msgq_hub_chk.sv
module msgq_hub_chk #(
   parameter int          N_QUEUES = 4,
   parameter int          DEPTH    = 4,
   parameter int          CNT_W    = 3,
   parameter logic [63:0] RX_MASK  = 64'hA
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_wr,
   input logic                           bus_rd,
   input logic [N_QUEUES-1:0]            irq_o,
   input logic [N_QUEUES-1:0][CNT_W-1:0] q_cnt,
   input logic [N_QUEUES-1:0]            q_ovf
);
   for (genvar g = 0; g < N_QUEUES; g++) begin : g_a
      // R2: a count only moves after a bus access
      assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_wr && !bus_rd) |=> $stable(q_cnt[g]));
      // R3: never more messages than the depth
      assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
         q_cnt[g] <= CNT_W'(DEPTH));
      // R3: overflow flag is sticky
      assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
         q_ovf[g] |=> q_ovf[g]);
      // R8: an interrupt only drops after a read
      assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_o[g]) |-> $past(bus_rd));
      if (!RX_MASK[g]) begin : g_tx
         // R8: transmit queues never interrupt
         assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_o[g]);
      end
   end
endmodule

bind msgq_hub msgq_hub_chk #(
   .N_QUEUES(N_QUEUES),
   .DEPTH   (DEPTH),
   .CNT_W   (CNT_W),
   .RX_MASK (RX_MASK)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .bus_wr(bus_wr),
   .bus_rd(bus_rd),
   .irq_o (irq_o),
   .q_cnt (q_cnt),
   .q_ovf (q_ovf)
);

// File: tb/msgq_hub_test.sv
module msgq_hub_test;
   localparam int NQ    = 4;
   localparam int DEP   = 4;
   localparam int NPX   = 2;
   localparam logic [3:0] RXM = 4'b1010;

   typedef logic [511:0] msg_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NQ-1:0] irq_o;

   int checks = 0;
   int errors = 0;
   bit run = 0;
   bit done = 0;

   msg_t        mq  [NQ][$];
   logic [31:0] stg [NQ][15];
   logic        movf [NQ];

   always #5 clk = ~clk;

   msgq_hub uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic void chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endfunction

   function automatic int adr(int p, int q, int r);
      return p * 'h10000 + q * 'h80 + r * 4;
   endfunction

   function automatic int sadr(int q);
      return 'h80000 + q * 4;
   endfunction

   // Behavioural model: returns read value, applies side effects
   function automatic logic [31:0] mdl(int a, bit wr, logic [31:0] wd);
      int p, q, r, off;
      msg_t m;
      logic [31:0] v;
      if (a >= 'h80000) begin
         off = a - 'h80000;
         q = off / 4;
         if (wr || off % 4 != 0 || q >= NQ) return '0;
         v = '0;
         v[23:12] = 12'(mq[q].size());
         v[0] = movf[q];
         return v;
      end
      p = a >> 16; q = (a >> 7) & 511; r = (a >> 2) & 31;
      if (p >= NPX || q >= NQ || r < 16 || a % 4 != 0) return '0;
      if (wr) begin
         if (r < 31) stg[q][r-16] = wd;
         else begin
            for (int i = 0; i < 15; i++) m[i*32 +: 32] = stg[q][i];
            m[480 +: 32] = wd;
            if (mq[q].size() < DEP) mq[q].push_back(m);
            else movf[q] = 1'b1;
            for (int i = 0; i < 15; i++) stg[q][i] = '0;
         end
         return '0;
      end
      if (mq[q].size() == 0) return '0;
      m = mq[q][0];
      v = m[(r-16)*32 +: 32];
      if (r == 31) void'(mq[q].pop_front());
      return v;
   endfunction

   task automatic wr(int a, logic [31:0] d);
      bus_addr = 20'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      void'(mdl(a, 1'b1, d));
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, string tag);
      logic [31:0] e;
      bus_addr = 20'(a); bus_rd = 1'b1;
      @(posedge clk);
      e = mdl(a, 1'b0, '0);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(tag, bus_rdata, e);
   endtask

   task automatic send(int p, int q, logic [31:0] base);
      for (int r = 16; r < 32; r++) wr(adr(p, q, r), base + 32'(r));
   endtask

   task automatic drain_msg(int p, int q, string tag);
      for (int r = 16; r < 32; r++) rd(adr(p, q, r), tag);
   endtask

   // R8: per-clock comparison of interrupts with the model
   always @(negedge clk) begin
      if (run) begin
         for (int q = 0; q < NQ; q++)
            chk("R8 irq", 32'(irq_o[q]), 32'(RXM[q] && mq[q].size() > 0));
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int q = 0; q < NQ; q++) begin
         movf[q] = 1'b0;
         for (int i = 0; i < 15; i++) stg[q][i] = '0;
      end
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 rdata", bus_rdata, '0);
      chk("R11 irq", 32'(irq_o), '0);
      rst_n = 1'b1;
      @(negedge clk);
      run = 1;
      for (int q = 0; q < NQ; q++) rd(sadr(q), "R11 state");

      // R1 R2 R5: write via proxy 0, read words via proxy 1
      send(0, 1, 32'hA000_0000);
      rd(sadr(1), "R7 count one");
      for (int r = 16; r < 31; r++) rd(adr(1, 1, r), "R5 peek");
      rd(sadr(1), "R5 count unchanged");
      rd(adr(0, 1, 20), "R1 proxy alias");
      rd(adr(1, 1, 31), "R4 pop last word");
      rd(sadr(1), "R4 count after pop");

      // R4: ordering and wrap over several rounds
      for (int k = 0; k < 3; k++) begin
         send(1, 3, 32'h3000_0000 + 32'(k) * 32'h100);
         rd(sadr(3), "R7 count rise");
      end
      drain_msg(0, 3, "R4 order first");
      send(0, 3, 32'h3000_0500);
      send(0, 3, 32'h3000_0600);
      for (int k = 0; k < 4; k++) drain_msg(1, 3, "R4 order wrap");
      rd(sadr(3), "R4 drained");

      // R9: short messages see cleared staging
      for (int r = 16; r < 21; r++) wr(adr(0, 0, r), 32'hC0DE_0000 + 32'(r));
      wr(adr(0, 0, 31), 32'h0);
      wr(adr(0, 0, 16), 32'h1111_2222);
      wr(adr(0, 0, 31), 32'h0);
      drain_msg(0, 0, "R9 first short");
      drain_msg(0, 0, "R9 stage cleared");

      // R6: empty queue reads
      rd(adr(0, 0, 18), "R6 empty peek");
      rd(adr(0, 0, 31), "R6 empty pop");
      rd(sadr(0), "R6 count stays zero");

      // R3: overflow on queue 2
      for (int k = 0; k < 5; k++) send(0, 2, 32'h2200_0000 + 32'(k) * 32'h10);
      rd(sadr(2), "R3 full with overflow");
      drain_msg(1, 2, "R3 survivor head");
      rd(sadr(2), "R3 overflow sticky");

      // R10: ignored accesses, then look at state and reads
      wr(adr(0, 1, 5), 32'hDEAD_BEEF);
      wr(adr(2, 1, 31), 32'hDEAD_BEEF);
      wr(adr(0, 5, 31), 32'hDEAD_BEEF);
      wr(sadr(1), 32'hFFFF_FFFF);
      wr(adr(0, 1, 31) + 2, 32'hDEAD_BEEF);
      rd(sadr(1), "R10 state untouched");
      rd(adr(0, 1, 5), "R10 low register");
      rd(adr(3, 1, 16), "R10 bad proxy");
      rd(sadr(9), "R10 status beyond");
      rd(adr(0, 1, 16), "R10 staging untouched");

      // R12: simultaneous write and read acts as write only
      send(0, 1, 32'h5500_0000);
      rd(adr(0, 1, 16), "R12 before");
      bus_addr = 20'(adr(0, 1, 31)); bus_wdata = 32'h77; bus_wr = 1'b1; bus_rd = 1'b1;
      @(posedge clk);
      void'(mdl(adr(0, 1, 31), 1'b1, 32'h77));
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R12 rdata held", bus_rdata, 32'h5500_0010);
      rd(sadr(1), "R12 write took effect");
      drain_msg(0, 1, "R12 drain");
      drain_msg(1, 1, "R12 drain second");

      run = 0;
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule